// File: doc/BRIEF.md
# Two-Stage Chained Synchronous FIFO

This block builds one deeper single-clock FIFO from two identical storage stages placed back to back. A producer writes into the first stage; a small link controller moves words from the first stage into the second; a consumer reads from the second stage. Each stage holds 8-bit words in a 16-entry memory. A build-time parameter selects the read behaviour of both stages.

In standard mode a read request returns its word, flagged by `valid`, on the following clock. In first-word-fall-through mode each stage keeps its head word already on its output with `valid` high. A read request takes that word in the same cycle it is asserted. A two-word prefetch buffer in each stage gives this mode four words more capacity than standard mode.

The link must not drop or repeat words in either mode. In standard mode the link stops issuing reads to the first stage once the second stage reports almost full. That leaves room for the one word still in flight. In first-word-fall-through mode a word counts as moved only in a cycle where the first stage's `valid` and the link's read request are both high.

Top module: `fifo_chain`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, `empty` is 1 and `valid`, `full` and `almost_full` are 0.
- R2: In standard mode, a read accepted at a clock edge (`rd_en`=1 and `empty`=0) drives its word on `rd_data` with `valid`=1 for the one cycle after that edge. In every other cycle `valid` is 0 and `rd_data` holds its value.
- R3: In standard mode, the link issues a read to the first stage only while the first stage is not empty and the second stage holds fewer than DEPTH-1 words. The second stage is never written while it is full.
- R4: In first-word-fall-through mode, whenever the chain holds a word, `valid` is 1 and the oldest word is on `rd_data` before any read. `valid` is always the inverse of `empty`. The head word stays stable until it is read.
- R5: In first-word-fall-through mode, a word leaves a stage only in a cycle where that stage's `valid` and its read request are both 1. The second stage's write enable is exactly that product.
- R6: Writing on every cycle into an empty chain fills it with exactly 32 words in standard mode and exactly 36 words in first-word-fall-through mode.
- R7: A write while `full` is 1, or a read while `empty` is 1, has no effect on the stored words or their count.
- R8: `full` and `almost_full` report the first stage. `almost_full` is 1 when that stage holds at least DEPTH-1 words, and `full` is 1 when it holds DEPTH words.
- R9: Words leave the chain in the order they were accepted, with none lost and none repeated. This holds under a read rate of one read every four cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, all logic on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write request, accepted when `full` is 0 |
| wr_data | input | 8 | Word to write |
| full | output | 1 | First stage holds DEPTH words |
| almost_full | output | 1 | First stage holds at least DEPTH-1 words |
| rd_en | input | 1 | Read request, accepted when a word is available |
| rd_data | output | 8 | Read word (next cycle in standard mode, head word in fall-through mode) |
| empty | output | 1 | Second stage has no readable word |
| valid | output | 1 | `rd_data` carries a word (see R2 and R4) |

## Verification
The assertions assume that `rst` is held high for at least one clock before use. They also assume that in standard mode the consumer samples `rd_data` only while `valid` is high. No assumption is made about `wr_en` or `rd_en` against the flags. The bench writes into a full chain and reads from an empty one on purpose, so that the ignore paths run under the same checks. In fall-through mode the bench raises `rd_en` only while `valid` is high. In standard mode it raises `rd_en` only while `empty` is low, except in the scenario that tests reads on an empty chain.

// File: rtl/fifo_chain_pkg.sv
`timescale 1ns/1ps
package fifo_chain_pkg;
  typedef enum logic {
    MODE_STD  = 1'b0,
    MODE_FWFT = 1'b1
  } rd_mode_e;
endpackage

// File: rtl/chain_core.sv
`timescale 1ns/1ps
// Plain synchronous FIFO: registered read port, one-cycle read latency.
module chain_core #(
  parameter int W     = 8,
  parameter int DEPTH = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [W-1:0] din,
  output logic         full,
  output logic         almost_full,
  input  logic         rd_en,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         valid
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] count;
  logic          do_wr, do_rd;

  assign full        = (count == CW'(DEPTH));
  assign almost_full = (count >= CW'(DEPTH - 1));
  assign empty       = (count == '0);
  assign do_wr       = wr_en && !full;
  assign do_rd       = rd_en && !empty;

  // storage and read register carry no reset so block RAM can be inferred
  always_ff @(posedge clk) begin
    if (do_wr) mem[wptr] <= din;
    if (do_rd) dout <= mem[rptr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
      valid <= 1'b0;
    end else begin
      if (do_wr) wptr <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
      if (do_rd) rptr <= (rptr == AW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
      count <= count + CW'(do_wr) - CW'(do_rd);
      valid <= do_rd;
    end
  end
endmodule

// File: rtl/chain_stage.sv
`timescale 1ns/1ps
// One storage stage: a core FIFO, optionally followed by a two-word
// prefetch buffer that presents the head word before it is requested.
module chain_stage
  import fifo_chain_pkg::*;
#(
  parameter int       W     = 8,
  parameter int       DEPTH = 16,
  parameter rd_mode_e MODE  = MODE_STD
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [W-1:0] din,
  output logic         full,
  output logic         almost_full,
  input  logic         rd_en,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         valid
);
  generate
    if (MODE == MODE_STD) begin : g_std
      chain_core #(.W(W), .DEPTH(DEPTH)) i_core (
        .clk(clk), .rst(rst),
        .wr_en(wr_en), .din(din), .full(full), .almost_full(almost_full),
        .rd_en(rd_en), .dout(dout), .empty(empty), .valid(valid)
      );
    end else begin : g_fwft
      localparam int PF = 2;

      logic         core_empty, core_valid, core_rd, pop;
      logic [W-1:0] core_dout;
      logic [1:0]   occ;
      logic [2:0]   occ_after;
      logic         wsel, rsel;
      logic [W-1:0] slot [PF];

      chain_core #(.W(W), .DEPTH(DEPTH)) i_core (
        .clk(clk), .rst(rst),
        .wr_en(wr_en), .din(din), .full(full), .almost_full(almost_full),
        .rd_en(core_rd), .dout(core_dout), .empty(core_empty), .valid(core_valid)
      );

      assign pop       = rd_en && (occ != 2'd0);
      // words held or landing after this edge, counting the one in flight
      assign occ_after = 3'(occ) + 3'(core_valid) - 3'(pop);
      assign core_rd   = !core_empty && (occ_after < 3'(PF));

      always_ff @(posedge clk) begin
        if (core_valid) slot[wsel] <= core_dout;
      end

      always_ff @(posedge clk) begin
        if (rst) begin
          occ  <= 2'd0;
          wsel <= 1'b0;
          rsel <= 1'b0;
        end else begin
          occ <= occ_after[1:0];
          if (core_valid) wsel <= ~wsel;
          if (pop)        rsel <= ~rsel;
        end
      end

      assign dout  = slot[rsel];
      assign valid = (occ != 2'd0);
      assign empty = (occ == 2'd0);
    end
  endgenerate
endmodule

// File: rtl/chain_link.sv
`timescale 1ns/1ps
// Flow control between the two stages.
module chain_link
  import fifo_chain_pkg::*;
#(
  parameter rd_mode_e MODE = MODE_STD
) (
  input  logic up_empty,
  input  logic up_valid,
  input  logic dn_full,
  input  logic dn_almost_full,
  output logic up_rd,
  output logic dn_wr
);
  generate
    if (MODE == MODE_STD) begin : g_std
      // stop one entry early: the word issued last cycle is still in flight
      assign up_rd = !up_empty && !dn_almost_full;
      assign dn_wr = up_valid;
    end else begin : g_fwft
      assign up_rd = up_valid && !dn_full;
      assign dn_wr = up_valid && up_rd;
    end
  endgenerate
endmodule

// File: rtl/fifo_chain.sv
`timescale 1ns/1ps
module fifo_chain
  import fifo_chain_pkg::*;
#(
  parameter int       W     = 8,
  parameter int       DEPTH = 16,
  parameter rd_mode_e MODE  = MODE_STD
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic         full,
  output logic         almost_full,
  input  logic         rd_en,
  output logic [W-1:0] rd_data,
  output logic         empty,
  output logic         valid
);
  logic         up_empty, up_valid, up_rd;
  logic [W-1:0] up_dout;
  logic         dn_full, dn_almost_full, link_wr;

  chain_stage #(.W(W), .DEPTH(DEPTH), .MODE(MODE)) i_stage0 (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .din(wr_data), .full(full), .almost_full(almost_full),
    .rd_en(up_rd), .dout(up_dout), .empty(up_empty), .valid(up_valid)
  );

  chain_link #(.MODE(MODE)) i_link (
    .up_empty(up_empty), .up_valid(up_valid),
    .dn_full(dn_full), .dn_almost_full(dn_almost_full),
    .up_rd(up_rd), .dn_wr(link_wr)
  );

  chain_stage #(.W(W), .DEPTH(DEPTH), .MODE(MODE)) i_stage1 (
    .clk(clk), .rst(rst),
    .wr_en(link_wr), .din(up_dout), .full(dn_full), .almost_full(dn_almost_full),
    .rd_en(rd_en), .dout(rd_data), .empty(empty), .valid(valid)
  );
endmodule

// File: rtl/fifo_chain_chk.sv
`timescale 1ns/1ps
module fifo_chain_chk
  import fifo_chain_pkg::*;
#(
  parameter int       W    = 8,
  parameter rd_mode_e MODE = MODE_STD
) (
  input logic         clk,
  input logic         rst,
  input logic         full,
  input logic         almost_full,
  input logic         rd_en,
  input logic [W-1:0] rd_data,
  input logic         empty,
  input logic         valid,
  input logic         up_valid,
  input logic         up_rd,
  input logic         link_wr,
  input logic         dn_full
);
  // R1
  reset_state_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (empty && !valid && !full && !almost_full));

  // R8
  full_has_af_chk: assert property (@(posedge clk) disable iff (rst)
    full |-> almost_full);

  // R3
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    link_wr |-> !dn_full);

  generate
    if (MODE == MODE_STD) begin : g_std
      // R2
      valid_after_read_chk: assert property (@(posedge clk) disable iff (rst)
        valid |-> $past(rd_en && !empty));
      // R2
      data_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(rd_en && !empty) |=> $stable(rd_data));
    end else begin : g_fwft
      // R4
      valid_vs_empty_chk: assert property (@(posedge clk) disable iff (rst)
        valid != empty);
      // R4
      head_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (valid && !rd_en) |=> (valid && $stable(rd_data)));
      // R5
      move_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
        link_wr |-> (up_valid && up_rd));
    end
  endgenerate
endmodule

bind fifo_chain fifo_chain_chk #(.W(W), .MODE(MODE)) i_chk (
  .clk(clk), .rst(rst), .full(full), .almost_full(almost_full),
  .rd_en(rd_en), .rd_data(rd_data), .empty(empty), .valid(valid),
  .up_valid(up_valid), .up_rd(up_rd), .link_wr(link_wr), .dn_full(dn_full)
);

// File: tb/test_fifo_chain.sv
`timescale 1ns/1ps
module test_fifo_chain;
  import fifo_chain_pkg::*;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en   [2];
  logic [7:0] wr_data [2];
  logic       rd_en   [2];
  logic [7:0] rd_data [2];
  logic       full [2], almost_full [2], empty [2], valid [2];

  int compared   = 0;
  int mismatched = 0;

  always #2 clk = ~clk;  // 250 MHz

  // index 0: standard mode, index 1: fall-through mode
  fifo_chain #(.W(8), .DEPTH(16), .MODE(MODE_STD)) i_fifo_chain (
    .clk(clk), .rst(rst), .wr_en(wr_en[0]), .wr_data(wr_data[0]),
    .full(full[0]), .almost_full(almost_full[0]), .rd_en(rd_en[0]),
    .rd_data(rd_data[0]), .empty(empty[0]), .valid(valid[0]));

  fifo_chain #(.W(8), .DEPTH(16), .MODE(MODE_FWFT)) i_fifo_chain_fwft (
    .clk(clk), .rst(rst), .wr_en(wr_en[1]), .wr_data(wr_data[1]),
    .full(full[1]), .almost_full(almost_full[1]), .rd_en(rd_en[1]),
    .rd_data(rd_data[1]), .empty(empty[1]), .valid(valid[1]));

  task automatic check(input string req, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic t_reset_flags(input int s);
    check("R1 empty after reset", int'(empty[s]), 1);
    check("R1 valid after reset", int'(valid[s]), 0);
    check("R1 full after reset", int'(full[s]), 0);
    check("R1 almost_full after reset", int'(almost_full[s]), 0);
  endtask

  // writes every cycle for 'cycles' cycles; words are base, base+1, ...
  // a write offered while full carries 8'hEE and must be dropped (R7)
  task automatic t_fill(input int s, input int cycles, input int max_words,
                        input logic [7:0] base, output int accepted);
    accepted = 0;
    for (int c = 0; c < cycles; c++) begin
      @(negedge clk);
      if (accepted < max_words && !full[s]) begin
        wr_en[s]   = 1'b1;
        wr_data[s] = base + 8'(accepted);
        accepted++;
      end else begin
        wr_en[s]   = (accepted >= max_words) ? 1'b0 : 1'b1;
        wr_data[s] = 8'hEE;
      end
    end
    @(negedge clk);
    wr_en[s] = 1'b0;
  endtask

  // one read every 4 cycles; checks order and total (R9)
  task automatic t_drain(input int s, input int expect_n, input logic [7:0] base);
    int  got = 0;
    logic prev_rd = 1'b0;
    for (int c = 0; c < expect_n * 4 + 24; c++) begin
      @(negedge clk);
      if (s == 0) begin
        check("R2 valid one cycle after accepted read", int'(valid[s]), int'(prev_rd));
        if (valid[s]) begin
          check("R9 standard word order", int'(rd_data[s]), int'(base + 8'(got)));
          got++;
        end
        rd_en[s] = ((c % 4) == 0) && !empty[s];
        prev_rd  = rd_en[s];
      end else begin
        if ((c % 4) == 0 && valid[s]) begin
          check("R9 fall-through word order", int'(rd_data[s]), int'(base + 8'(got)));
          got++;
          rd_en[s] = 1'b1;
        end else begin
          rd_en[s] = 1'b0;
        end
      end
    end
    rd_en[s] = 1'b0;
    @(negedge clk);
    check("R9 words out equal words in", got, expect_n);
    check("R9 empty after drain", int'(empty[s]), 1);
    check("R9 valid low after drain", int'(valid[s]), 0);
  endtask

  task automatic t_full_capacity(input int s);
    int n;
    int exp_n = (s == 0) ? 32 : 36;
    t_fill(s, 160, 1000, 8'h00, n);
    check("R6 words accepted until full", n, exp_n);
    check("R8 full when first stage full", int'(full[s]), 1);
    check("R8 almost_full when first stage full", int'(almost_full[s]), 1);
    check("R6 not empty when full", int'(empty[s]), 0);
    if (s == 0) begin
      repeat (3) begin
        @(negedge clk);
        check("R2 no valid without read", int'(valid[s]), 0);
      end
    end else begin
      @(negedge clk);
      check("R4 head valid before any read", int'(valid[s]), 1);
      check("R4 head word is oldest", int'(rd_data[s]), 0);
    end
    // R7: extra writes while full were offered during the fill; drain proves none stuck
    t_drain(s, exp_n, 8'h00);
  endtask

  task automatic t_read_empty(input int s);
    @(negedge clk);
    rd_en[s] = 1'b1;
    repeat (2) @(negedge clk);
    rd_en[s] = 1'b0;
    check("R7 read on empty leaves no valid", int'(valid[s]), 0);
    check("R7 read on empty keeps empty", int'(empty[s]), 1);
    @(negedge clk);
    check("R7 no late valid after empty read", int'(valid[s]), 0);
  endtask

  task automatic t_short_burst(input int s);
    int n;
    t_fill(s, 5, 5, 8'h40, n);
    check("R9 short burst accepted", n, 5);
    repeat (8) @(negedge clk);
    if (s == 1) begin
      check("R5 head moved through link", int'(rd_data[s]), 8'h40);
      check("R4 valid equals not empty", int'(valid[s]), int'(!empty[s]));
    end
    t_drain(s, 5, 8'h40);
  endtask

  initial begin
    for (int s = 0; s < 2; s++) begin
      wr_en[s] = 1'b0; wr_data[s] = 8'h00; rd_en[s] = 1'b0;
    end
    repeat (4) @(negedge clk);
    for (int s = 0; s < 2; s++) t_reset_flags(s);
    rst = 1'b0;
    @(negedge clk);
    for (int s = 0; s < 2; s++) t_reset_flags(s);
    for (int s = 0; s < 2; s++) begin
      t_read_empty(s);
      t_full_capacity(s);
      t_short_burst(s);
      t_read_empty(s);
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule